// File: doc/BRIEF.md
# Bus Lock and Request/Grant Arbiter

This block drives the active-low bus-lock output of a processor's bus interface and decides when an external master that asks for the local bus may take it. A lock starts in the cycle after the lock prefix is decoded and lasts until the last bus cycle of the instruction that follows the prefix ends. This lets a read and the matching write of a memory exchange run with no foreign cycle between them. A second lock source covers the two back-to-back interrupt-acknowledge cycles. That lock starts at the second clock state of the first acknowledge cycle and ends at the second clock state of the second.

A request that arrives while the lock is held is not dropped. It is recorded, and the grant pulse is issued on the same clock edge on which the lock output goes inactive. When no lock is held, a request is granted at the end of the running bus cycle, or at once when the bus is idle. After a grant, the block holds off new processor bus cycles until the external master returns a release pulse. Further requests are ignored from the time one is recorded until that release.

Top module: `lock_arbiter`

## Requirements
- R1: After reset, `lock_n` is 1, `gnt` is 0 and `hold` is 0.
- R2: One clock edge after a cycle with `pfx_stb` high, `lock_n` is 0.
- R3: A prefix lock ends (`lock_n` returns to 1 at the next edge) only in a cycle where `cyc_end` and `instr_last` are both 1. A `cyc_end` with `instr_last` 0 leaves the lock in place. If `pfx_stb` is high in the same cycle, it wins.
- R4: `ack_t2` with `ack_second` 0 sets the acknowledge lock at the next edge. `ack_t2` with `ack_second` 1 clears it at the next edge.
- R5: While `lock_n` is 0, `gnt` stays 0 and a `req_stb` pulse is stored.
- R6: A stored request produces `gnt` on the same edge on which `lock_n` rises.
- R7: Without lock, a request (new or stored) is granted at the edge after a cycle with `cyc_end` 1, or at the next edge if `bus_busy` is 0.
- R8: `gnt` lasts one cycle. `hold` is 1 from the grant edge until the edge after a cycle with `rel_stb` 1.
- R9: A `req_stb` while a request is stored or granted is dropped. After the release, no extra grant follows. A `rel_stb` with no grant outstanding is ignored.
- R10: With both lock sources active, `lock_n` stays 0 until both have ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_stb | input | 1 | Lock prefix decoded (one cycle) |
| cyc_end | input | 1 | Current bus cycle ends this clock |
| instr_last | input | 1 | The ending bus cycle is the instruction's last |
| bus_busy | input | 1 | A processor bus cycle is in progress |
| ack_t2 | input | 1 | Second clock state of an acknowledge cycle |
| ack_second | input | 1 | That acknowledge cycle is the second of the pair |
| req_stb | input | 1 | External master bus request pulse |
| rel_stb | input | 1 | External master release pulse |
| lock_n | output | 1 | Bus lock, active low |
| gnt | output | 1 | Grant pulse to the external master |
| hold | output | 1 | External master owns the bus; processor cycle start held off |

## Verification
The checker watches, on every cycle, that a prefix strobe is followed by an active lock, that no grant coincides with an active lock, that grants are single pulses that raise `hold`, and that no second grant appears while the bus is owned. Only the bench scenarios show the ordering cases: a request stored during a lock and granted exactly on the release edge, a cycle end that is not the instruction's last holding the lock, overlapping prefix and acknowledge locks, and requests dropped while one is outstanding. The bench runs a cycle-accurate reference model beside directed and random traffic.

// File: rtl/lock_arbiter_pkg.sv
package lock_arbiter_pkg;
   typedef enum logic [1:0] {
      ARB_FREE  = 2'd0,
      ARB_PEND  = 2'd1,
      ARB_OWNED = 2'd2
   } arb_state_t;
endpackage

// File: rtl/lock_tracker.sv
module lock_tracker #(
   parameter int ACK_LOCK_EN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pfx_stb,
   input  logic cyc_end,
   input  logic instr_last,
   input  logic ack_t2,
   input  logic ack_second,
   output logic lock_q,
   output logic lock_nxt
);
   logic pfx_q, pfx_d;
   logic ack_q, ack_d;

   // prefix lock: set by the decode strobe, cleared by the last cycle end
   always_comb begin
      pfx_d = pfx_q;
      if (pfx_stb)
         pfx_d = 1'b1;
      else if (cyc_end && instr_last)
         pfx_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pfx_q <= 1'b0;
      else        pfx_q <= pfx_d;
   end

   generate
      if (ACK_LOCK_EN != 0) begin : g_ack
         always_comb begin
            ack_d = ack_q;
            if (ack_t2) ack_d = !ack_second;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= ack_d;
         end
      end else begin : g_no_ack
         assign ack_d = 1'b0;
         assign ack_q = 1'b0;
      end
   endgenerate

   assign lock_nxt = pfx_d | ack_d;

   always_ff @(posedge clk) begin
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= lock_nxt;
   end
endmodule

// File: rtl/grant_fsm.sv
module grant_fsm
   import lock_arbiter_pkg::*;
#(
   parameter int IDLE_GRANT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_stb,
   input  logic rel_stb,
   input  logic cyc_end,
   input  logic bus_busy,
   input  logic lock_nxt,
   output logic gnt,
   output logic hold
);
   arb_state_t st_q, st_d;
   logic want, slot, fire;

   generate
      if (IDLE_GRANT != 0) begin : g_idle
         assign slot = cyc_end | ~bus_busy;
      end else begin : g_end_only
         assign slot = cyc_end;
      end
   endgenerate

   assign want = (st_q == ARB_PEND) || (st_q == ARB_FREE && req_stb);
   assign fire = want && !lock_nxt && slot;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ARB_OWNED: if (rel_stb) st_d = ARB_FREE;
         ARB_PEND:  if (fire)    st_d = ARB_OWNED;
         default:   st_d = fire ? ARB_OWNED : (want ? ARB_PEND : ARB_FREE);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ARB_FREE;
         gnt  <= 1'b0;
      end else begin
         st_q <= st_d;
         gnt  <= fire;
      end
   end

   assign hold = (st_q == ARB_OWNED);
endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter #(
   parameter int IDLE_GRANT  = 1,
   parameter int ACK_LOCK_EN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pfx_stb,
   input  logic cyc_end,
   input  logic instr_last,
   input  logic bus_busy,
   input  logic ack_t2,
   input  logic ack_second,
   input  logic req_stb,
   input  logic rel_stb,
   output logic lock_n,
   output logic gnt,
   output logic hold
);
   generate
      if (IDLE_GRANT < 0 || IDLE_GRANT > 1) begin : g_bad_idle
         $error("IDLE_GRANT must be 0 or 1");
      end
      if (ACK_LOCK_EN < 0 || ACK_LOCK_EN > 1) begin : g_bad_ack
         $error("ACK_LOCK_EN must be 0 or 1");
      end
   endgenerate

   logic lock_q, lock_nxt;

   lock_tracker #(.ACK_LOCK_EN(ACK_LOCK_EN)) u_lock (
      .clk(clk), .rst_n(rst_n), .pfx_stb(pfx_stb), .cyc_end(cyc_end),
      .instr_last(instr_last), .ack_t2(ack_t2), .ack_second(ack_second),
      .lock_q(lock_q), .lock_nxt(lock_nxt)
   );

   grant_fsm #(.IDLE_GRANT(IDLE_GRANT)) u_gnt (
      .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .rel_stb(rel_stb),
      .cyc_end(cyc_end), .bus_busy(bus_busy), .lock_nxt(lock_nxt),
      .gnt(gnt), .hold(hold)
   );

   assign lock_n = ~lock_q;
endmodule

// File: rtl/lock_arbiter_chk.sv
module lock_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic pfx_stb,
   input logic rel_stb,
   input logic lock_n,
   input logic gnt,
   input logic hold
);
   a_r2_lock_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_stb |=> !lock_n);
   a_r5_no_grant_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |-> lock_n);
   a_r8_grant_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |=> !gnt);
   a_r8_grant_raises_hold: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |-> hold);
   a_r9_no_regrant_owned: assert property (@(posedge clk) disable iff (!rst_n)
      hold && !rel_stb |=> hold && !gnt);
endmodule

bind lock_arbiter lock_arbiter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pfx_stb(pfx_stb), .rel_stb(rel_stb),
   .lock_n(lock_n), .gnt(gnt), .hold(hold)
);

// File: tb/sim_lock_arbiter.sv
module sim_lock_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pfx_stb = 0, cyc_end = 0, instr_last = 0, bus_busy = 0;
   logic ack_t2 = 0, ack_second = 0, req_stb = 0, rel_stb = 0;
   logic lock_n, gnt, hold;

   int n_vec = 0, n_bad = 0, cyc_cnt = 0;

   // reference model state
   bit m_pfx = 0, m_ack = 0, m_lock = 0, m_gnt = 0;
   int m_st = 0;  // 0 free, 1 pending, 2 owned

   always #(CLK_PERIOD/2) clk = ~clk;

   lock_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .pfx_stb(pfx_stb), .cyc_end(cyc_end),
      .instr_last(instr_last), .bus_busy(bus_busy), .ack_t2(ack_t2),
      .ack_second(ack_second), .req_stb(req_stb), .rel_stb(rel_stb),
      .lock_n(lock_n), .gnt(gnt), .hold(hold)
   );

   function automatic void chk(string tag, logic act, logic exp, string what);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cyc_cnt);
      end
   endfunction

   // model advance for one clock edge
   function automatic void model_step();
      bit np, na, nl, want, slot, fire;
      np = pfx_stb ? 1'b1 : ((cyc_end && instr_last) ? 1'b0 : m_pfx);
      na = ack_t2 ? !ack_second : m_ack;
      nl = np | na;
      want = (m_st == 1) || (m_st == 0 && req_stb);
      slot = cyc_end || !bus_busy;
      fire = want && !nl && slot && (m_st != 2);
      if (m_st == 2) m_st = rel_stb ? 0 : 2;
      else m_st = fire ? 2 : (want ? 1 : 0);
      m_pfx = np; m_ack = na; m_lock = nl; m_gnt = fire;
   endfunction

   task automatic step(string tag, bit p, bit ce, bit il, bit bb, bit a2, bit as,
                       bit rq, bit rl);
      pfx_stb = p; cyc_end = ce; instr_last = il; bus_busy = bb;
      ack_t2 = a2; ack_second = as; req_stb = rq; rel_stb = rl;
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk(tag, lock_n, !m_lock, "lock_n");
      chk(tag, gnt, m_gnt, "gnt");
      chk(tag, hold, m_st == 2, "hold");
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 1, 0, 0, 0, 0);
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      chk("R1", lock_n, 1'b1, "lock_n");
      chk("R1", gnt, 1'b0, "gnt");
      chk("R1", hold, 1'b0, "hold");

      // R2 then R3: prefix lock, non-last cycle end keeps it
      step("R2", 1, 0, 0, 1, 0, 0, 0, 0);
      chk("R2", lock_n, 1'b0, "lock_n literal");
      step("R3", 0, 1, 0, 1, 0, 0, 0, 0);
      chk("R3", lock_n, 1'b0, "lock_n held");
      // R5: request stored during lock
      step("R5", 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R5", gnt, 1'b0, "gnt in lock");
      idle("R5", 3);
      // R6: grant exactly at release edge
      step("R6", 0, 1, 1, 1, 0, 0, 0, 0);
      chk("R6", lock_n, 1'b1, "lock_n released");
      chk("R6", gnt, 1'b1, "gnt at release");
      // R8: pulse and hold; R9: extra request dropped
      step("R8", 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R8", gnt, 1'b0, "gnt pulse");
      chk("R8", hold, 1'b1, "hold");
      step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
      chk("R8", hold, 1'b0, "hold after release");
      idle("R9", 4);
      chk("R9", gnt, 1'b0, "no regrant");
      step("R9", 0, 0, 0, 0, 0, 0, 0, 1);
      chk("R9", hold, 1'b0, "stray release");

      // R7: busy bus waits for cycle end; idle bus grants at once
      step("R7", 0, 0, 0, 1, 0, 0, 1, 0);
      chk("R7", gnt, 1'b0, "busy no grant");
      step("R7", 0, 1, 0, 1, 0, 0, 0, 0);
      chk("R7", gnt, 1'b1, "grant at cycle end");
      step("R7", 0, 0, 0, 0, 0, 0, 0, 1);
      step("R7", 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R7", gnt, 1'b1, "idle grant");
      step("R7", 0, 0, 0, 0, 0, 0, 0, 1);

      // R4 and R10: acknowledge window overlapping prefix lock
      step("R4", 0, 0, 0, 1, 1, 0, 0, 0);
      chk("R4", lock_n, 1'b0, "ack lock");
      step("R10", 1, 0, 0, 1, 0, 0, 0, 0);
      step("R10", 0, 1, 1, 1, 0, 0, 0, 0);
      chk("R10", lock_n, 1'b0, "ack still holds");
      step("R4", 0, 0, 0, 1, 1, 1, 0, 0);
      chk("R4", lock_n, 1'b1, "ack release");
      idle("R4", 2);

      // random traffic against the model (R2..R10)
      for (int i = 0; i < N_RANDOM; i++) begin
         bit own, p, ce, il, bb, a2, as, rq, rl;
         own = (m_st == 2);
         bb = ($urandom % 4) != 0;
         p  = !own && ($urandom % 16) == 0;
         ce = !own && bb && ($urandom % 4) == 0;
         il = ($urandom % 3) == 0;
         a2 = !own && ($urandom % 20) == 0;
         as = $urandom % 2;
         rq = ($urandom % 6) == 0;
         rl = ($urandom % 5) == 0;
         step("R7/R5/R3 random", p, ce, il, bb, a2, as, rq, rl);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule